// File: doc/BRIEF.md
# Power-on option configuration sequencer

This block brings up a small processor core whose configuration options are kept as words in program memory rather than being fixed in silicon. When the power-good input is high, the block first holds the core in reset for a fixed number of clock cycles. It then reads a contiguous run of option words from a reserved region of program memory, one read per cycle, and latches them into configuration registers. After a further settling interval it lets the core run, and the core starts fetching from address 0.

From the latched words the block decodes four options: a watchdog enable, a port A pull-down enable, a three-way instruction cycle-time select (2.67 µs, 13.33 µs or 40 µs) and a choice between LCD drive and general-purpose output on the segment pins. Until the core runs, the pin controls stay at safe values: pull-downs off and segments in LCD mode. A low power-good input resets the block at once, whatever state it is in.

Both intervals are parameters counted in clock cycles. The defaults give 75 ms and 1 ms at 250 MHz, and a bench can use short values.

Top module: `optboot_seq`

## Requirements
- R1: While powerGood is low, all of the following hold: coreRstN=0, setupDone=0, memRd=0, memAddr=OPT_BASE, every latched word is 0, every decoded option is 0, pinPullEn=0 and pinSegGpo=0.
- R2: After powerGood goes high, exactly HOLD_CYCLES rising clock edges pass before the first memory read is issued.
- R3: The load phase issues OPT_COUNT reads at addresses OPT_BASE, OPT_BASE+1, up to OPT_BASE+OPT_COUNT-1. The default range is 2020h to 2033h. The reads come on consecutive cycles with memRd=1, each address once. No read is issued outside that range, so the pattern region 2000h to 201Fh is never read. When memRd=0, memAddr equals OPT_BASE.
- R4: memory data has one cycle of latency. The word returned for read k is stored in word k of optWords, at bits [k*DATA_W+DATA_W-1 : k*DATA_W].
- R5: The last word is captured on the edge that ends the load phase. After that edge, exactly SETUP_CYCLES further edges pass, and then coreRstN and setupDone both go to 1. They stay at 1 while powerGood stays high. The core is never out of reset while a read is pending.
- R6: optWdtEn is bit 0 of word 0. optPullEn is bit 0 of word 1. optSegGpo is bit 0 of word 3, where 1 selects general-purpose output and 0 selects LCD.
- R7: optCycleSel is decoded from bits [1:0] of word 2. Code 0 selects 2.67 µs, code 1 selects 13.33 µs and code 2 selects 40 µs. The unused code 3 is output as 0.
- R8: pinPullEn equals setupDone AND optPullEn. pinSegGpo equals setupDone AND optSegGpo. Before the core runs, both are 0.
- R9: A fall of powerGood in any state, including mid-load and run, immediately restores the R1 values without waiting for a clock. When powerGood rises again, the full hold period restarts.
- R10: The latched words change only on edges taken while in the load phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| powerGood | input | 1 | Power good; low acts as asynchronous reset |
| memAddr | output | ADDR_W | Program memory read address |
| memRd | output | 1 | Read strobe, data expected next cycle |
| memData | input | DATA_W | Program memory read data |
| optWords | output | OPT_COUNT*DATA_W | All latched option words, word 0 in the low bits |
| optWdtEn | output | 1 | Decoded watchdog enable |
| optPullEn | output | 1 | Decoded port A pull-down enable |
| optCycleSel | output | 2 | Decoded cycle time: 0 = 2.67 µs, 1 = 13.33 µs, 2 = 40 µs |
| optSegGpo | output | 1 | Decoded segment mode: 1 = general-purpose output |
| pinPullEn | output | 1 | Effective pull-down control for the pads |
| pinSegGpo | output | 1 | Effective segment mode control for the pads |
| coreRstN | output | 1 | Core reset, active low; high lets the core run from address 0 |
| setupDone | output | 1 | High only while the core runs |

## Verification
The assertions assume that memory data is valid on the edge after a read and stays unchanged between reads. The bench memory model registers its output only on cycles with memRd high. The assertions are disabled while powerGood is low, and they assume powerGood changes away from the active clock edge. The bench drops and raises powerGood only a short time after a falling edge, and it reprograms the memory contents only while powerGood is low.

// File: rtl/optboot_pkg.sv
package optboot_pkg;

  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_LOAD = 2'd1,
    ST_WAIT = 2'd2,
    ST_RUN  = 2'd3
  } boot_state_e;

  localparam int IDX_W = 8;

  localparam logic [1:0] CT_FAST = 2'd0;
  localparam logic [1:0] CT_MID  = 2'd1;
  localparam logic [1:0] CT_SLOW = 2'd2;

  typedef struct packed {
    logic             rdEn;
    logic [IDX_W-1:0] rdIdx;
    logic             capEn;
    logic [IDX_W-1:0] capIdx;
    logic             running;
  } dp_ctl_t;

endpackage

// File: rtl/optboot_ctrl.sv
module optboot_ctrl
  import optboot_pkg::*;
#(
  parameter int HOLD_CYCLES  = 18_750_000,
  parameter int SETUP_CYCLES = 250_000,
  parameter int OPT_COUNT    = 20
) (
  input  logic        clk,
  input  logic        powerGood,
  output dp_ctl_t     ctl,
  output boot_state_e curState
);

  localparam int CNT_MAX = (HOLD_CYCLES > SETUP_CYCLES) ? HOLD_CYCLES : SETUP_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int HOLD_LIM  = HOLD_CYCLES - 1;
  localparam int SETUP_LIM = SETUP_CYCLES - 1;

  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood) begin
      curState <= ST_HOLD;
      cnt      <= '0;
      idx      <= '0;
    end else begin
      unique case (curState)
        ST_HOLD: begin
          if (cnt == CNT_W'(HOLD_LIM)) begin
            curState <= ST_LOAD;
            cnt      <= '0;
            idx      <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_LOAD: begin
          if (idx == IDX_W'(OPT_COUNT)) begin
            curState <= ST_WAIT;
            cnt      <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_WAIT: begin
          if (cnt == CNT_W'(SETUP_LIM)) begin
            curState <= ST_RUN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RUN: begin
          curState <= ST_RUN;
        end
        default: curState <= ST_HOLD;
      endcase
    end
  end

  always_comb begin
    ctl.rdEn    = (curState == ST_LOAD) && (idx < IDX_W'(OPT_COUNT));
    ctl.rdIdx   = idx;
    ctl.capEn   = (curState == ST_LOAD) && (idx != '0);
    ctl.capIdx  = idx - 1'b1;
    ctl.running = (curState == ST_RUN);
  end

endmodule

// File: rtl/optboot_dp.sv
module optboot_dp
  import optboot_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int OPT_COUNT = 20,
  parameter int OPT_BASE  = 'h2020
) (
  input  logic                        clk,
  input  logic                        powerGood,
  input  dp_ctl_t                     ctl,
  input  logic [DATA_W-1:0]           memData,
  output logic [ADDR_W-1:0]           memAddr,
  output logic                        memRd,
  output logic [OPT_COUNT*DATA_W-1:0] optWords,
  output logic                        optWdtEn,
  output logic                        optPullEn,
  output logic [1:0]                  optCycleSel,
  output logic                        optSegGpo,
  output logic                        pinPullEn,
  output logic                        pinSegGpo,
  output logic                        coreRstN,
  output logic                        setupDone
);

  localparam int WDT_WORD  = 0;
  localparam int PULL_WORD = 1;
  localparam int CYC_WORD  = 2;
  localparam int SEG_WORD  = 3;
  localparam logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(OPT_BASE);

  logic [DATA_W-1:0] wordQ [OPT_COUNT];
  logic [1:0]        rawCyc;

  for (genvar g = 0; g < OPT_COUNT; g++) begin : gWord
    always_ff @(posedge clk or negedge powerGood) begin
      if (!powerGood) begin
        wordQ[g] <= '0;
      end else if (ctl.capEn && (ctl.capIdx == IDX_W'(g))) begin
        wordQ[g] <= memData;
      end
    end
    assign optWords[g*DATA_W +: DATA_W] = wordQ[g];
  end

  always_comb begin
    memRd   = ctl.rdEn;
    memAddr = ctl.rdEn ? (BASE_ADDR + ADDR_W'(ctl.rdIdx)) : BASE_ADDR;
  end

  always_comb begin
    rawCyc      = wordQ[CYC_WORD][1:0];
    optWdtEn    = wordQ[WDT_WORD][0];
    optPullEn   = wordQ[PULL_WORD][0];
    optSegGpo   = wordQ[SEG_WORD][0];
    unique case (rawCyc)
      CT_MID:  optCycleSel = CT_MID;
      CT_SLOW: optCycleSel = CT_SLOW;
      default: optCycleSel = CT_FAST;
    endcase
  end

  always_comb begin
    coreRstN  = ctl.running;
    setupDone = ctl.running;
    pinPullEn = ctl.running & optPullEn;
    pinSegGpo = ctl.running & optSegGpo;
  end

endmodule

// File: rtl/optboot_seq.sv
module optboot_seq
  import optboot_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int OPT_COUNT    = 20,
  parameter int OPT_BASE     = 'h2020,
  parameter int HOLD_CYCLES  = 18_750_000,
  parameter int SETUP_CYCLES = 250_000
) (
  input  logic                        clk,
  input  logic                        powerGood,
  output logic [ADDR_W-1:0]           memAddr,
  output logic                        memRd,
  input  logic [DATA_W-1:0]           memData,
  output logic [OPT_COUNT*DATA_W-1:0] optWords,
  output logic                        optWdtEn,
  output logic                        optPullEn,
  output logic [1:0]                  optCycleSel,
  output logic                        optSegGpo,
  output logic                        pinPullEn,
  output logic                        pinSegGpo,
  output logic                        coreRstN,
  output logic                        setupDone
);

  dp_ctl_t     ctl;
  boot_state_e curState;

  optboot_ctrl #(
    .HOLD_CYCLES (HOLD_CYCLES),
    .SETUP_CYCLES(SETUP_CYCLES),
    .OPT_COUNT   (OPT_COUNT)
  ) ctrlI (
    .clk      (clk),
    .powerGood(powerGood),
    .ctl      (ctl),
    .curState (curState)
  );

  optboot_dp #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .OPT_COUNT(OPT_COUNT),
    .OPT_BASE (OPT_BASE)
  ) dpI (
    .clk        (clk),
    .powerGood  (powerGood),
    .ctl        (ctl),
    .memData    (memData),
    .memAddr    (memAddr),
    .memRd      (memRd),
    .optWords   (optWords),
    .optWdtEn   (optWdtEn),
    .optPullEn  (optPullEn),
    .optCycleSel(optCycleSel),
    .optSegGpo  (optSegGpo),
    .pinPullEn  (pinPullEn),
    .pinSegGpo  (pinSegGpo),
    .coreRstN   (coreRstN),
    .setupDone  (setupDone)
  );

endmodule

// File: rtl/optboot_chk.sv
module optboot_chk
  import optboot_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int OPT_COUNT = 20,
  parameter int OPT_BASE  = 'h2020
) (
  input logic                        clk,
  input logic                        powerGood,
  input boot_state_e                 curState,
  input logic                        memRd,
  input logic [ADDR_W-1:0]           memAddr,
  input logic [OPT_COUNT*DATA_W-1:0] optWords,
  input logic [1:0]                  optCycleSel,
  input logic                        pinPullEn,
  input logic                        pinSegGpo,
  input logic                        setupDone,
  input logic                        coreRstN
);

  localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(OPT_BASE);
  localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(OPT_BASE + OPT_COUNT - 1);

  assert_rd_in_range_R3: assert property (@(posedge clk) disable iff (!powerGood)
    memRd |-> (memAddr >= LO_ADDR && memAddr <= HI_ADDR));

  assert_rd_first_base_R3: assert property (@(posedge clk) disable iff (!powerGood)
    $rose(memRd) |-> (memAddr == LO_ADDR));

  assert_rd_ascending_R3: assert property (@(posedge clk) disable iff (!powerGood)
    (memRd && $past(memRd)) |-> (memAddr == ADDR_W'($past(memAddr) + 1'b1)));

  assert_run_after_wait_R5: assert property (@(posedge clk) disable iff (!powerGood)
    $rose(setupDone) |-> ($past(curState) == ST_WAIT));

  assert_no_run_while_read_R5: assert property (@(posedge clk) disable iff (!powerGood)
    memRd |-> !coreRstN);

  assert_no_code3_R7: assert property (@(posedge clk) disable iff (!powerGood)
    optCycleSel != 2'b11);

  assert_safe_pins_R8: assert property (@(posedge clk) disable iff (!powerGood)
    !setupDone |-> (!pinPullEn && !pinSegGpo));

  assert_words_frozen_R10: assert property (@(posedge clk) disable iff (!powerGood)
    (curState != ST_LOAD) |=> $stable(optWords));

endmodule

bind optboot_seq optboot_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .OPT_COUNT(OPT_COUNT),
  .OPT_BASE (OPT_BASE)
) chkI (
  .clk        (clk),
  .powerGood  (powerGood),
  .curState   (curState),
  .memRd      (memRd),
  .memAddr    (memAddr),
  .optWords   (optWords),
  .optCycleSel(optCycleSel),
  .pinPullEn  (pinPullEn),
  .pinSegGpo  (pinSegGpo),
  .setupDone  (setupDone),
  .coreRstN   (coreRstN)
);

// File: tb/optboot_seq_test.sv
`timescale 1ns/1ps
module optboot_seq_test;

  localparam int AW = 16, DW = 8, NW = 20, BASE = 'h2020;
  localparam int HOLD = 40, SETUP = 12;

  logic clk = 1'b0;
  logic powerGood = 1'b0;
  logic [AW-1:0] memAddr;
  logic memRd;
  logic [DW-1:0] memData = '0;
  logic [NW*DW-1:0] optWords;
  logic optWdtEn, optPullEn, optSegGpo, pinPullEn, pinSegGpo, coreRstN, setupDone;
  logic [1:0] optCycleSel;

  int checks = 0, fails = 0;
  logic [4:0] seed = 5'd0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  optboot_seq #(.ADDR_W(AW), .DATA_W(DW), .OPT_COUNT(NW), .OPT_BASE(BASE),
                .HOLD_CYCLES(HOLD), .SETUP_CYCLES(SETUP)) uut (
    .clk(clk), .powerGood(powerGood), .memAddr(memAddr), .memRd(memRd), .memData(memData),
    .optWords(optWords), .optWdtEn(optWdtEn), .optPullEn(optPullEn), .optCycleSel(optCycleSel),
    .optSegGpo(optSegGpo), .pinPullEn(pinPullEn), .pinSegGpo(pinSegGpo),
    .coreRstN(coreRstN), .setupDone(setupDone));

  function automatic logic [7:0] memVal(input int a);
    logic [7:0] v;
    int off = a - BASE;
    if (off < 0 || off >= NW) return 8'hEE;
    v = 8'(off * 29 + int'(seed) * 7 + 3);
    if (off == 0) v[0] = seed[0];
    if (off == 1) v[0] = seed[1];
    if (off == 2) v[1:0] = seed[3:2];
    if (off == 3) v[0] = seed[4];
    return v;
  endfunction

  always @(posedge clk) if (memRd) memData <= memVal(int'(memAddr));

  // behavioural reference model
  int mSt = 0, mCnt = 0, mIdx = 0;
  logic [7:0] mW [NW];
  initial for (int i = 0; i < NW; i++) mW[i] = 8'h00;

  always @(posedge clk or negedge powerGood) begin
    if (!powerGood) begin
      mSt = 0; mCnt = 0; mIdx = 0;
      for (int i = 0; i < NW; i++) mW[i] = 8'h00;
    end else begin
      case (mSt)
        0: if (mCnt == HOLD - 1) begin mSt = 1; mCnt = 0; mIdx = 0; end else mCnt++;
        1: begin
          if (mIdx >= 1) mW[mIdx-1] = memVal(BASE + mIdx - 1);
          if (mIdx == NW) begin mSt = 2; mCnt = 0; end else mIdx++;
        end
        2: if (mCnt == SETUP - 1) mSt = 3; else mCnt++;
        default: ;
      endcase
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  logic [NW*DW-1:0] expWords;
  always_comb for (int i = 0; i < NW; i++) expWords[i*DW +: DW] = mW[i];

  always @(negedge clk) begin
    automatic bit run = (mSt == 3);
    automatic bit rd = (mSt == 1) && (mIdx < NW);
    automatic logic [1:0] cyc = (mW[2][1:0] == 2'b11) ? 2'b00 : mW[2][1:0];
    if (!finished) begin
      chk("R5 coreRstN", coreRstN, run);
      chk("R5 setupDone", setupDone, run);
      chk("R3 memRd", memRd, rd);
      chk("R3 memAddr", memAddr, rd ? BASE + mIdx : BASE);
      chk(mSt == 1 ? "R4 optWords" : "R10 optWords", optWords, expWords);
      chk("R6 optWdtEn", optWdtEn, mW[0][0]);
      chk("R6 optPullEn", optPullEn, mW[1][0]);
      chk("R6 optSegGpo", optSegGpo, mW[3][0]);
      chk("R7 optCycleSel", optCycleSel, cyc);
      chk("R8 pinPullEn", pinPullEn, run & mW[1][0]);
      chk("R8 pinSegGpo", pinSegGpo, run & mW[3][0]);
    end
  end

  task automatic finishRun();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic checkIdle(input string tag);
    chk({tag, " coreRstN"}, coreRstN, 0);
    chk({tag, " setupDone"}, setupDone, 0);
    chk({tag, " memRd"}, memRd, 0);
    chk({tag, " memAddr"}, memAddr, BASE);
    chk({tag, " optWords"}, optWords, 0);
    chk({tag, " pins"}, {pinPullEn, pinSegGpo}, 0);
    chk({tag, " options"}, {optWdtEn, optPullEn, optSegGpo, optCycleSel}, 0);
  endtask

  task automatic bootAndCheck(input logic [4:0] s, input logic [1:0] expCyc);
    int n = 0;
    seed = s;
    @(negedge clk); #1 powerGood = 1'b1;
    do begin @(negedge clk); n++; end while (!memRd && n < 1000);
    chk("R2 hold length", n, HOLD);
    n = 0;
    do begin @(negedge clk); n++; end while (!setupDone && n < 1000);
    chk("R5 load+setup length", n, NW + 1 + SETUP);
    chk("R6 wdt", optWdtEn, s[0]);
    chk("R6 pull", optPullEn, s[1]);
    chk("R7 cycle", optCycleSel, expCyc);
    chk("R6 seg", optSegGpo, s[4]);
    chk("R8 pin pull", pinPullEn, s[1]);
    chk("R8 pin seg", pinSegGpo, s[4]);
    chk("R4 last word", optWords[(NW-1)*DW +: DW], memVal(BASE + NW - 1));
    repeat (5) @(negedge clk);
    chk("R10 words steady in run", optWords[2*DW +: DW], memVal(BASE + 2));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    checkIdle("R1");
    bootAndCheck(5'b10011, 2'd0);
    #1 powerGood = 1'b0; #1;
    checkIdle("R9 drop in run");
    bootAndCheck(5'b00110, 2'd1);
    #1 powerGood = 1'b0;
    @(negedge clk); #1 powerGood = 1'b1;
    repeat (HOLD + 8) @(negedge clk);
    chk("R9 mid-load reading", memRd, 1);
    #1 powerGood = 1'b0; #1;
    checkIdle("R9 drop in load");
    bootAndCheck(5'b11101, 2'd0);
    #1 powerGood = 1'b0;
    @(negedge clk); #1 powerGood = 1'b1;
    repeat (HOLD + NW + 4) @(negedge clk);
    chk("R8 safe during wait", {pinPullEn, pinSegGpo, setupDone}, 0);
    #1 powerGood = 1'b0; #1;
    checkIdle("R9 drop in wait");
    bootAndCheck(5'b11010, 2'd2);
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      finishRun();
    end
  end

endmodule